// File: doc/BRIEF.md
# Truth-Table Trigger Engine for a 16-Channel Sampler

This block decides, on every sample, whether a 16-channel logic capture should trigger. The channels are grouped into four quads of four. Each quad looks up its four bits in a 16-entry truth table and produces one match bit. Three banks of such tables exist. One bank performs value/mask matching. The other two act as single-channel level detectors whose present and previous outputs feed a small 16-entry combining table. That combining table is what turns a level into a rise or fall condition.

The tables are loaded one index at a time. A 16-bit staging word holds the bit for that index in every table. A separate commit write then stores the staged bits at the chosen index. Once armed, the block evaluates each valid sample. It emits a single-cycle trigger pulse on the first hit and then disarms until it is armed again.

Top module: `lut_trigger`

## Requirements
- R1: Quad q sees channels 4q to 4q+3, and channel 4q+k is bit k of its table index. The quad's match bit is the table bit at that index.
- R2: A bank's result is the AND of its four quad match bits. This holds for the value/mask bank and for both detector banks.
- R3: The combining table is indexed as follows: bit 0 is detector 0 now, bit 1 is detector 0 on the previous evaluated sample, bit 2 is detector 1 now, and bit 3 is detector 1 previous. A rise term on detector 0 is table 0x2222. A fall term on detector 1 is table 0x0F00.
- R4: A sample hits when the value/mask result AND the combining-table bit are both 1. With an all-ones combining table, the value/mask result alone decides.
- R5: Staging-word layout: bits 3:0 are the value/mask quads 0 to 3, bit 4 is the combining table, bits 11:8 are the detector-0 quads, and bits 15:12 are the detector-1 quads. Bits 7:5 are ignored. A commit code whose upper nibble is 0x3 stores the staged bits at index equal to the code's lower nibble, in every table.
- R6: A commit whose code has an upper nibble other than 0x3 changes no table. Staging alone, without a commit, changes no table.
- R7: After reset all tables are zero, the block is disarmed, and trig_o is 0. As a result, arming with unprogrammed tables never triggers.
- R8: Arming sets the block armed and clears both previous-detector bits to 0. Arming takes priority over a sample in the same cycle, and that sample is not evaluated.
- R9: trig_o is 1 in the cycle after a hitting valid sample while armed, and only for one cycle. The block then disarms, and later samples give no trigger until it is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stage_we_i | input | 1 | Load staging word |
| stage_data_i | input | 16 | Staging word (layout in R5) |
| commit_we_i | input | 1 | Commit write strobe |
| commit_code_i | input | 8 | Commit code: 0x3 in the upper nibble, index in the lower nibble |
| arm_i | input | 1 | Arm the trigger |
| sample_valid_i | input | 1 | Sample present this cycle |
| sample_i | input | 16 | Channel sample |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench builds the block with its default geometry of four quads of four channels. That geometry matches the fixed staging-word layout, so every table bit of every bank can be reached through the load port. Random tables and samples exercise the indexing of all four quads and all sixteen combining-table entries. Directed cases cover rise and fall detection, the clearing of the previous-detector state on arming, and commits with invalid codes.

// File: rtl/lut_trig_pkg.sv
package lut_trig_pkg;
  localparam int unsigned QUADS  = 4;
  localparam int unsigned QUAD_W = 4;
  localparam int unsigned CH     = QUADS * QUAD_W;
  localparam int unsigned DEPTH  = 1 << QUAD_W;
  localparam int unsigned IDX_W  = QUAD_W;

  typedef logic [DEPTH-1:0]            tbl_t;
  typedef logic [QUADS-1:0][DEPTH-1:0] bank_t;
  typedef logic [CH-1:0]               sample_t;
endpackage

// File: rtl/lut_trig_store.sv
module lut_trig_store
  import lut_trig_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stage_we_i,
  input  logic [15:0] stage_data_i,
  input  logic        commit_we_i,
  input  logic [7:0]  commit_code_i,
  output bank_t       vm_o,
  output bank_t       d0_o,
  output bank_t       d1_o,
  output tbl_t        glue_o
);
  localparam int unsigned GLUE_BIT = 4;
  localparam int unsigned D0_LSB   = 8;
  localparam int unsigned D1_LSB   = 12;

  logic [15:0]      stage_q;
  bank_t            vm_q, d0_q, d1_q;
  tbl_t             glue_q;
  logic             commit_ok;
  logic [IDX_W-1:0] idx;

  // bits 7:5 of the staging word carry tables this engine does not use
  logic unused_bits;
  assign unused_bits = ^stage_q[7:5];

  assign commit_ok = commit_we_i && (commit_code_i[7:4] == 4'h3);
  assign idx       = commit_code_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (stage_we_i) begin
      stage_q <= stage_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vm_q   <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      glue_q <= '0;
    end else if (commit_ok) begin
      for (int q = 0; q < QUADS; q++) begin
        vm_q[q][idx] <= stage_q[q];
        d0_q[q][idx] <= stage_q[D0_LSB+q];
        d1_q[q][idx] <= stage_q[D1_LSB+q];
      end
      glue_q[idx] <= stage_q[GLUE_BIT];
    end
  end

  assign vm_o   = vm_q;
  assign d0_o   = d0_q;
  assign d1_o   = d1_q;
  assign glue_o = glue_q;

  a_r6_bad_code_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_ok |=> ($stable(glue_q) && $stable(vm_q) && $stable(d0_q) && $stable(d1_q)));

  a_r5_commit_stores_glue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_ok |=> (glue_q[$past(idx)] == $past(stage_q[GLUE_BIT])));
endmodule

// File: rtl/lut_trig_bank.sv
module lut_trig_bank
  import lut_trig_pkg::*;
(
  input  bank_t   tbl_i,
  input  sample_t smp_i,
  output logic    hit_o
);
  logic [QUADS-1:0] q_hit;

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    assign q_hit[q] = tbl_i[q][smp_i[q*QUAD_W +: QUAD_W]];
  end

  assign hit_o = &q_hit;
endmodule

// File: rtl/lut_trigger.sv
module lut_trigger
  import lut_trig_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stage_we_i,
  input  logic [15:0] stage_data_i,
  input  logic        commit_we_i,
  input  logic [7:0]  commit_code_i,
  input  logic        arm_i,
  input  logic        sample_valid_i,
  input  logic [15:0] sample_i,
  output logic        trig_o
);
  bank_t      vm_tbl, d0_tbl, d1_tbl;
  tbl_t       glue_tbl;
  logic       vm_hit, d0_cur, d1_cur, hit;
  logic [1:0] prev_q;
  logic       armed_q, trig_q;
  logic [3:0] glue_idx;

  lut_trig_store u_store (
    .clk_i, .rst_ni, .stage_we_i, .stage_data_i, .commit_we_i, .commit_code_i,
    .vm_o(vm_tbl), .d0_o(d0_tbl), .d1_o(d1_tbl), .glue_o(glue_tbl)
  );

  lut_trig_bank u_vm (.tbl_i(vm_tbl), .smp_i(sample_i), .hit_o(vm_hit));
  lut_trig_bank u_d0 (.tbl_i(d0_tbl), .smp_i(sample_i), .hit_o(d0_cur));
  lut_trig_bank u_d1 (.tbl_i(d1_tbl), .smp_i(sample_i), .hit_o(d1_cur));

  assign glue_idx = {prev_q[1], d1_cur, prev_q[0], d0_cur};
  assign hit      = vm_hit & glue_tbl[glue_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      prev_q  <= '0;
      trig_q  <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      prev_q  <= '0;
      trig_q  <= 1'b0;
    end else if (sample_valid_i && armed_q) begin
      trig_q  <= hit;
      prev_q  <= {d1_cur, d0_cur};
      if (hit) armed_q <= 1'b0;
    end else begin
      trig_q <= 1'b0;
    end
  end

  assign trig_o = trig_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r9_needs_armed_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(armed_q && sample_valid_i && !arm_i));

  a_r9_disarm_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !armed_q);

  a_r8_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (armed_q && prev_q == 2'b00 && !trig_o));
endmodule

// File: tb/tb_lut_trigger.sv
module tb_lut_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stage_we = 1'b0;
  logic [15:0] stage_data = '0;
  logic        commit_we = 1'b0;
  logic [7:0]  commit_code = '0;
  logic        arm = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] sample = '0;
  logic        trig;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0][15:0] m_vm, m_d0, m_d1;
  logic [15:0]      m_glue;
  logic             m_armed;
  logic [1:0]       m_prev;

  always #5 clk = ~clk;

  lut_trigger dut (
    .clk_i(clk), .rst_ni(rst_n), .stage_we_i(stage_we), .stage_data_i(stage_data),
    .commit_we_i(commit_we), .commit_code_i(commit_code), .arm_i(arm),
    .sample_valid_i(valid), .sample_i(sample), .trig_o(trig)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s trig_o act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lut_entry(input logic [15:0] val, input logic [15:0] msk,
                                            input int q);
    logic [15:0] e = 16'hffff;
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 4; k++)
        if (msk[4*q+k] && (j[k] != val[4*q+k])) e[j] = 1'b0;
    return e;
  endfunction

  function automatic logic bank_hit(input logic [3:0][15:0] b, input logic [15:0] s);
    logic h = 1'b1;
    for (int q = 0; q < 4; q++) h &= b[q][s[4*q +: 4]];
    return h;
  endfunction

  task automatic set_model(input logic [15:0] vv, input logic [15:0] vmk,
                           input int ch0, input int ch1, input logic [15:0] g);
    for (int q = 0; q < 4; q++) begin
      m_vm[q] = lut_entry(vv, vmk, q);
      m_d0[q] = lut_entry(16'(1 << ch0), 16'(1 << ch0), q);
      m_d1[q] = lut_entry(16'(1 << ch1), 16'(1 << ch1), q);
    end
    m_glue = g;
  endtask

  task automatic load_all();
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      for (int q = 0; q < 4; q++) begin
        w[q]    = m_vm[q][i];
        w[8+q]  = m_d0[q][i];
        w[12+q] = m_d1[q][i];
      end
      w[4] = m_glue[i];
      @(negedge clk);
      valid = 1'b0; arm = 1'b0; commit_we = 1'b0;
      stage_we = 1'b1; stage_data = w;
      @(negedge clk);
      stage_we = 1'b0; commit_we = 1'b1; commit_code = {4'h3, 4'(i)};
    end
    @(negedge clk);
    commit_we = 1'b0;
  endtask

  task automatic arm_blk(input logic v, input logic [15:0] s);
    @(negedge clk);
    stage_we = 1'b0; commit_we = 1'b0;
    arm = 1'b1; valid = v; sample = s;
    m_armed = 1'b1; m_prev = 2'b00;
    @(posedge clk); #1;
    check("R8 arm cycle", trig, 1'b0);
    @(negedge clk);
    arm = 1'b0; valid = 1'b0;
  endtask

  task automatic smp(input string tag, input logic [15:0] s);
    logic h, c0, c1, vmh;
    @(negedge clk);
    arm = 1'b0; stage_we = 1'b0; commit_we = 1'b0;
    valid = 1'b1; sample = s;
    h = 1'b0;
    if (m_armed) begin
      c0  = bank_hit(m_d0, s);
      c1  = bank_hit(m_d1, s);
      vmh = bank_hit(m_vm, s);
      h = vmh & m_glue[{m_prev[1], c1, m_prev[0], c0}];
      m_prev = {c1, c0};
      if (h) m_armed = 1'b0;
    end
    @(posedge clk); #1;
    check(tag, trig, h);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; arm = 1'b0; stage_we = 1'b0; commit_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_vm = '0; m_d0 = '0; m_d1 = '0; m_glue = '0;
    m_armed = 1'b0; m_prev = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset trig_o", trig, 1'b0);
    rst_n = 1'b1;

    // R7: zero tables never hit
    arm_blk(1'b0, '0);
    smp("R7 zero tables", 16'h0000);
    smp("R7 zero tables", 16'hffff);

    // R4/R2/R1: value/mask only, all-ones glue
    set_model(16'hA5C3, 16'hF0FF, 0, 1, 16'hffff);
    load_all();
    arm_blk(1'b0, '0);
    smp("R2 vm miss", 16'hA5C2);
    smp("R1 vm miss quad3", 16'h55C3);
    smp("R4 vm hit", 16'hA0C3);
    smp("R9 no retrigger", 16'hA5C3);
    idle();

    // R8: arm priority over a same-cycle matching sample
    arm_blk(1'b1, 16'hA5C3);
    smp("R8 still armed", 16'hA5C3);

    // R6: invalid commit codes and stage-only writes change nothing
    @(negedge clk); stage_we = 1'b1; stage_data = 16'h0000;
    @(negedge clk); stage_we = 1'b0; commit_we = 1'b1; commit_code = 8'h25;
    @(negedge clk); commit_code = 8'hB0;
    @(negedge clk); commit_code = 8'h31; commit_we = 1'b0;
    idle();
    arm_blk(1'b0, '0);
    smp("R6 tables kept", 16'hA5C3);

    // R3: rise on channel 5 via detector 0, glue 0x2222
    set_model(16'h0000, 16'h0000, 5, 14, 16'h2222);
    load_all();
    arm_blk(1'b0, '0);
    smp("R3 rise low", 16'h0000);
    smp("R3 rise low", 16'hFFDF);
    smp("R3 rise fires", 16'h0020);

    // R3: fall on channel 14 via detector 1, glue 0x0F00
    set_model(16'h0000, 16'h0000, 5, 14, 16'h0F00);
    load_all();
    arm_blk(1'b0, '0);
    smp("R8 prev cleared no fall", 16'h0000);
    smp("R3 fall high", 16'h4000);
    smp("R3 fall fires", 16'h0000);
    arm_blk(1'b0, '0);
    smp("R3 high again", 16'h4000);
    arm_blk(1'b0, '0);
    smp("R8 rearm clears prev", 16'h0000);

    // R5/R1/R2/R3/R4: random tables and samples
    for (int r = 0; r < 40; r++) begin
      logic [15:0] vv, mk;
      vv = 16'($urandom);
      mk = 16'($urandom & $urandom & $urandom);
      for (int q = 0; q < 4; q++) begin
        m_vm[q] = lut_entry(vv, mk, q);
        m_d0[q] = 16'($urandom) | 16'($urandom);
        m_d1[q] = 16'($urandom) | 16'($urandom);
      end
      m_glue = 16'($urandom);
      load_all();
      arm_blk(1'b0, '0);
      for (int n = 0; n < 60; n++) begin
        if (!m_armed && ($urandom % 4 == 0)) arm_blk(1'b0, '0);
        if ($urandom % 5 == 0) idle();
        else smp("R5 random", ($urandom % 2 == 0) ? (vv ^ 16'($urandom & $urandom & 32'hffff)) : 16'($urandom));
      end
      idle();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule